// File: doc/BRIEF.md
# GPIO pin interrupt source selector

A bank of 32 pin-interrupt channels. Each channel picks one of up to 128 GPIO interrupt lines, watches it with a programmable sense mode (rising edge, falling edge, level high or level low) and keeps one status bit. It raises an active-high level request towards an upstream interrupt controller while that status bit is set and the channel is not masked. The GPIO lines are first passed through a two-stage synchroniser. A 128-to-1 multiplexer for each channel then picks the line, and edge detection compares the picked line with its value one cycle earlier.

Software programs the block over a simple 32-bit register bus. Writes take effect on the clock edge that samples `bus_wr`, and reads are combinational from `bus_addr`. Four byte-wide routing slots share one register. Each slot holds a 7-bit source index and an enable bit. The sense fields are spread over two registers of 16 channels each. Edge-latched status bits are cleared by writing zeros. When a channel's source index or enable changes, edge detection is suppressed for one cycle, so reprogramming a slot never produces a false edge.

Top module: `pin_irq_selector`

## Requirements
- R1: After reset, all routing, sense, status and mask registers read 0 and every request output is low.
- R2: Channel c is routed by the register at offset 0x30 + 4*(c/4), byte c%4 (bits 8*(c%4)+7 down to 8*(c%4)). In a slot, bit 7 enables the channel and bits 6:0 hold the GPIO source index. The written value reads back unchanged.
- R3: Channels 0 to 15 take their sense code from offset 0x24 and channels 16 to 31 from offset 0x28, at bits 2*(c%16)+1 down to 2*(c%16). The codes are: 0 rising edge, 1 falling edge, 2 level high, 3 level low.
- R4: In rising mode, a 0-to-1 transition of the selected source sets the channel's status bit (offset 0x20, bit c) and raises irq_o[c]. This happens no more than 4 clock cycles after the pin changes. The bit stays set after the pin is stable.
- R5: In falling mode, a 1-to-0 transition of the selected source sets the status bit and raises irq_o[c].
- R6: In the level modes, the status bit follows the selected source while the channel is enabled: high in level-high mode when the source is 1, high in level-low mode when the source is 0. Writing 0 to a level-mode status bit has no effect.
- R7: In the edge modes, writing a word to offset 0x20 clears each status bit whose written bit is 0. Bits written as 1 keep their value.
- R8: A channel whose enable bit is 0 never sets its status bit, whatever its source does.
- R9: A change of a slot's source index or enable bit does not set the status bit by itself, even when the old and new sources hold different levels.
- R10: The mask register at offset 0x10020 holds one bit per channel. A 1 forces irq_o[c] low without changing the status bit, and clearing the mask bit brings the request back.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| gpio_in | input | 128 | GPIO interrupt lines, asynchronous to clk |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | 17 | Register byte address |
| bus_wdata | input | 32 | Register write data |
| bus_rdata | output | 32 | Register read data, combinational from bus_addr |
| irq_o | output | 32 | Active-high level request per channel |

## Verification
The bench moves one channel to a source that holds a different level from the old source, and then enables a channel whose source is already high. A design that skipped the reload of the last sample on reprogramming would latch a phantom edge in both cases. It also drops the clear pattern onto a bit that is not its target, and writes zeros to a level-mode bit. A design that decoded the clear polarity wrongly would wipe unrelated channels, and a level channel that latched would not drop when its pin releases. Channels are placed in the upper sense register and in the upper bytes of a routing register, so a wrong shift or register index shows up as a channel that never fires. Toggling a disabled channel and masking a pending one checks that the enable gates detection and that the mask gates only the request.

// File: rtl/pirq_pkg.sv
package pirq_pkg;
   localparam int SLOT_W       = 8;
   localparam int SRC_IDX_W    = 7;
   localparam int SRC_SPAN     = 1 << SRC_IDX_W;
   localparam int CH_PER_SLOTR = 32 / SLOT_W;
   localparam int CH_PER_SNSR  = 16;
   localparam logic [31:0] OFS_STATUS = 32'h0000_0020;
   localparam logic [31:0] OFS_SENSE  = 32'h0000_0024;
   localparam logic [31:0] OFS_SLOT   = 32'h0000_0030;
   localparam logic [31:0] OFS_MASK   = 32'h0001_0020;

   typedef enum logic [1:0] {
      SNS_RISE = 2'd0,
      SNS_FALL = 2'd1,
      SNS_HIGH = 2'd2,
      SNS_LOW  = 2'd3
   } sense_e;
endpackage

// File: rtl/pirq_sync.sv
module pirq_sync #(
   parameter int W      = 128,
   parameter int STAGES = 2
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] d,
   output logic [W-1:0] q
);
   if (STAGES < 2) begin : g_bad
      $error("pirq_sync needs at least two stages");
   end

   logic [STAGES-1:0][W-1:0] pipe;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) pipe <= '0;
      else        pipe <= {pipe[STAGES-2:0], d};
   end

   assign q = pipe[STAGES-1];
endmodule

// File: rtl/pirq_regs.sv
module pirq_regs
   import pirq_pkg::*;
#(
   parameter int NUM_CH = 32,
   parameter int ADDR_W = 17,
   parameter int DATA_W = 32
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic                     bus_wr,
   input  logic [ADDR_W-1:0]        bus_addr,
   input  logic [DATA_W-1:0]        bus_wdata,
   output logic [DATA_W-1:0]        bus_rdata,
   input  logic [NUM_CH-1:0]        status_i,
   output logic [NUM_CH*SLOT_W-1:0] slot_o,
   output logic [NUM_CH*2-1:0]      sense_o,
   output logic [NUM_CH-1:0]        mask_o,
   output logic [NUM_CH-1:0]        clr_o
);
   localparam int N_SLOTR = NUM_CH / CH_PER_SLOTR;
   localparam int N_SNSR  = NUM_CH / CH_PER_SNSR;

   logic [N_SLOTR-1:0][DATA_W-1:0] slot_q;
   logic [N_SNSR-1:0][DATA_W-1:0]  sense_q;
   logic [NUM_CH-1:0]              mask_q;
   logic                           hit_status;

   assign hit_status = (bus_addr == ADDR_W'(OFS_STATUS));
   assign clr_o      = (bus_wr && hit_status) ? ~bus_wdata[NUM_CH-1:0] : '0;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         slot_q  <= '0;
         sense_q <= '0;
         mask_q  <= '0;
      end else if (bus_wr) begin
         for (int k = 0; k < N_SLOTR; k++)
            if (bus_addr == ADDR_W'(OFS_SLOT + 32'(4 * k))) slot_q[k] <= bus_wdata;
         for (int k = 0; k < N_SNSR; k++)
            if (bus_addr == ADDR_W'(OFS_SENSE + 32'(4 * k))) sense_q[k] <= bus_wdata;
         if (bus_addr == ADDR_W'(OFS_MASK)) mask_q <= bus_wdata[NUM_CH-1:0];
      end
   end

   always_comb begin
      bus_rdata = '0;
      if (hit_status) bus_rdata[NUM_CH-1:0] = status_i;
      if (bus_addr == ADDR_W'(OFS_MASK)) bus_rdata[NUM_CH-1:0] = mask_q;
      for (int k = 0; k < N_SLOTR; k++)
         if (bus_addr == ADDR_W'(OFS_SLOT + 32'(4 * k))) bus_rdata = slot_q[k];
      for (int k = 0; k < N_SNSR; k++)
         if (bus_addr == ADDR_W'(OFS_SENSE + 32'(4 * k))) bus_rdata = sense_q[k];
   end

   for (genvar c = 0; c < NUM_CH; c++) begin : g_fan
      assign slot_o[c*SLOT_W +: SLOT_W] =
         slot_q[c / CH_PER_SLOTR][SLOT_W*(c % CH_PER_SLOTR) +: SLOT_W];
      assign sense_o[2*c +: 2] =
         sense_q[c / CH_PER_SNSR][2*(c % CH_PER_SNSR) +: 2];
   end

   assign mask_o = mask_q;
endmodule

// File: rtl/pirq_chan.sv
module pirq_chan
   import pirq_pkg::*;
(
   input  logic                clk,
   input  logic                rst_n,
   input  logic [SRC_SPAN-1:0] src_vec,
   input  logic [SLOT_W-1:0]   slot,
   input  logic [1:0]          sense,
   input  logic                clr,
   output logic                status
);
   logic [SLOT_W-1:0] cfg_q;
   logic              prev_q;
   logic              sel;
   logic              en;
   logic              cfg_same;
   logic              edge_hit;
   sense_e            mode;

   assign en       = slot[SLOT_W-1];
   assign sel      = src_vec[slot[SRC_IDX_W-1:0]];
   assign cfg_same = (slot == cfg_q);
   assign mode     = sense_e'(sense);

   always_comb begin
      unique case (mode)
         SNS_RISE: edge_hit = sel & ~prev_q;
         SNS_FALL: edge_hit = ~sel & prev_q;
         default:  edge_hit = 1'b0;
      endcase
      edge_hit = edge_hit & en & cfg_same;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cfg_q  <= '0;
         prev_q <= 1'b0;
         status <= 1'b0;
      end else begin
         cfg_q  <= slot;
         prev_q <= sel;
         unique case (mode)
            SNS_HIGH: status <= en & sel;
            SNS_LOW:  status <= en & ~sel;
            default: begin
               if (edge_hit)  status <= 1'b1;
               else if (clr)  status <= 1'b0;
            end
         endcase
      end
   end
endmodule

// File: rtl/pin_irq_selector.sv
module pin_irq_selector
   import pirq_pkg::*;
#(
   parameter int NUM_CH      = 32,
   parameter int NUM_SRC     = 128,
   parameter int ADDR_W      = 17,
   parameter int DATA_W      = 32,
   parameter int SYNC_STAGES = 2
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic [NUM_SRC-1:0] gpio_in,
   input  logic               bus_wr,
   input  logic [ADDR_W-1:0]  bus_addr,
   input  logic [DATA_W-1:0]  bus_wdata,
   output logic [DATA_W-1:0]  bus_rdata,
   output logic [NUM_CH-1:0]  irq_o
);
   if (DATA_W != 32)                              begin : g_chk_dw  $error("DATA_W must be 32"); end
   if (NUM_CH % CH_PER_SNSR != 0 || NUM_CH > 32)  begin : g_chk_ch  $error("NUM_CH must be 16 or 32"); end
   if (NUM_SRC < 1 || NUM_SRC > SRC_SPAN)          begin : g_chk_src $error("NUM_SRC out of range"); end
   if (ADDR_W < 17)                               begin : g_chk_aw  $error("ADDR_W too small for mask offset"); end

   logic [NUM_SRC-1:0]        gpio_s;
   logic [SRC_SPAN-1:0]       src_vec;
   logic [NUM_CH*SLOT_W-1:0]  slot_w;
   logic [NUM_CH*2-1:0]       sense_w;
   logic [NUM_CH-1:0]         mask_w;
   logic [NUM_CH-1:0]         clr_w;
   logic [NUM_CH-1:0]         status_w;

   pirq_sync #(.W(NUM_SRC), .STAGES(SYNC_STAGES)) u_sync (
      .clk(clk), .rst_n(rst_n), .d(gpio_in), .q(gpio_s));

   if (NUM_SRC == SRC_SPAN) begin : g_full
      assign src_vec = gpio_s;
   end else begin : g_pad
      assign src_vec = {{(SRC_SPAN-NUM_SRC){1'b0}}, gpio_s};
   end

   pirq_regs #(.NUM_CH(NUM_CH), .ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_regs (
      .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
      .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .status_i(status_w),
      .slot_o(slot_w), .sense_o(sense_w), .mask_o(mask_w), .clr_o(clr_w));

   for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
      pirq_chan u_chan (
         .clk(clk), .rst_n(rst_n), .src_vec(src_vec),
         .slot(slot_w[c*SLOT_W +: SLOT_W]), .sense(sense_w[2*c +: 2]),
         .clr(clr_w[c]), .status(status_w[c]));
   end

   assign irq_o = status_w & ~mask_w;
endmodule

// File: rtl/pin_irq_selector_chk.sv
module pin_irq_selector_chk #(
   parameter int NUM_CH = 32,
   parameter int ADDR_W = 17,
   parameter int DATA_W = 32
) (
   input logic                clk,
   input logic                rst_n,
   input logic                bus_wr,
   input logic [ADDR_W-1:0]   bus_addr,
   input logic [DATA_W-1:0]   bus_wdata,
   input logic [NUM_CH-1:0]   irq_o,
   input logic [NUM_CH-1:0]   status_w,
   input logic [NUM_CH*8-1:0] slot_w,
   input logic [NUM_CH*2-1:0] sense_w,
   input logic [NUM_CH-1:0]   mask_w
);
   logic clr_wr;
   assign clr_wr = bus_wr && (bus_addr == ADDR_W'(32'h20));

   for (genvar c = 0; c < NUM_CH; c++) begin : g_a
      // R8: a disabled channel cannot raise its status
      a_r8_disabled_no_set: assert property (@(posedge clk) disable iff (!rst_n)
         !$past(slot_w[8*c+7]) |-> !$rose(status_w[c]));
      // R9: a slot change in an edge mode never sets status
      a_r9_reprog_no_edge: assert property (@(posedge clk) disable iff (!rst_n)
         (!$stable(slot_w[8*c +: 8]) && !sense_w[2*c+1]) |=> !$rose(status_w[c]));
      // R7: an edge-mode status bit only falls after a zero written to it
      a_r7_clear_by_write: assert property (@(posedge clk) disable iff (!rst_n)
         ($fell(status_w[c]) && !$past(sense_w[2*c+1]))
            |-> $past(clr_wr && !bus_wdata[c]));
      // R10: a request appears only with new status or a released mask
      a_r10_irq_source: assert property (@(posedge clk) disable iff (!rst_n)
         $rose(irq_o[c]) |-> ($rose(status_w[c]) || $fell(mask_w[c])));
      // R10: a masked channel keeps its request low
      a_r10_masked_low: assert property (@(posedge clk) disable iff (!rst_n)
         mask_w[c] |-> !irq_o[c]);
   end
endmodule

bind pin_irq_selector pin_irq_selector_chk #(.NUM_CH(NUM_CH), .ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_chk (
   .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
   .irq_o(irq_o), .status_w(status_w), .slot_w(slot_w), .sense_w(sense_w), .mask_w(mask_w));

// File: tb/tb_pin_irq_selector.sv
module tb_pin_irq_selector;
   logic         clk = 1'b0;
   logic         rst_n = 1'b0;
   logic [127:0] gpio = '0;
   logic         wr = 1'b0;
   logic [16:0]  addr = '0;
   logic [31:0]  wdata = '0;
   logic [31:0]  rdata;
   logic [31:0]  irq;
   int           checks = 0;
   int           fails = 0;
   bit           done = 1'b0;

   localparam logic [16:0] A_STAT = 17'h00020, A_SNS0 = 17'h00024, A_SNS1 = 17'h00028,
                           A_SLT0 = 17'h00030, A_SLT1 = 17'h00034, A_SLT4 = 17'h00040,
                           A_SLT7 = 17'h0004C, A_MASK = 17'h10020;

   always #2 clk = ~clk;

   pin_irq_selector dut (
      .clk(clk), .rst_n(rst_n), .gpio_in(gpio), .bus_wr(wr), .bus_addr(addr),
      .bus_wdata(wdata), .bus_rdata(rdata), .irq_o(irq));

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic bw(input logic [16:0] a, input logic [31:0] d);
      @(negedge clk); wr = 1'b1; addr = a; wdata = d;
      @(negedge clk); wr = 1'b0;
   endtask

   task automatic br(input logic [16:0] a, output logic [31:0] d);
      @(negedge clk); addr = a; #1 d = rdata;
   endtask

   task automatic settle();
      repeat (4) @(posedge clk);
      #1;
   endtask

   task automatic pin(input int idx, input logic v);
      @(negedge clk); gpio[idx] = v;
   endtask

   task automatic t_reset();
      logic [31:0] d;
      chk("R1 irq after reset", irq, 32'h0);
      br(A_STAT, d); chk("R1 status after reset", d, 32'h0);
      br(A_MASK, d); chk("R1 mask after reset", d, 32'h0);
      br(A_SLT0, d); chk("R1 slot0 after reset", d, 32'h0);
      br(A_SNS1, d); chk("R1 sense1 after reset", d, 32'h0);
   endtask

   task automatic t_rising();
      logic [31:0] d;
      bw(A_SLT0, 32'h0000_0085);
      br(A_SLT0, d); chk("R2 slot readback", d, 32'h0000_0085);
      settle();
      chk("R4 no status before edge", irq[0], 1'b0);
      pin(5, 1'b1); settle();
      chk("R4 rising edge raises irq0", irq[0], 1'b1);
      br(A_STAT, d); chk("R4 status bit0 set", d & 32'h1, 32'h1);
   endtask

   task automatic t_falling();
      logic [31:0] d;
      bw(A_SNS1, 32'h0000_0004);
      br(A_SNS1, d); chk("R3 sense1 readback", d, 32'h0000_0004);
      pin(100, 1'b1); settle();
      bw(A_SLT4, 32'h0000_E400);
      br(A_SLT4, d); chk("R2 slot4 byte1 readback", d, 32'h0000_E400);
      settle();
      chk("R5 no status while high", irq[17], 1'b0);
      pin(100, 1'b0); settle();
      chk("R5 falling edge raises irq17", irq[17], 1'b1);
   endtask

   task automatic t_mask();
      logic [31:0] d;
      bw(A_MASK, 32'h1); settle();
      chk("R10 masked irq0 low", irq[0], 1'b0);
      br(A_STAT, d); chk("R10 status kept under mask", d & 32'h1, 32'h1);
      bw(A_MASK, 32'h0); settle();
      chk("R10 unmask restores irq0", irq[0], 1'b1);
   endtask

   task automatic t_clear();
      logic [31:0] d;
      bw(A_STAT, 32'hFFFF_FFFF); settle();
      br(A_STAT, d); chk("R7 write ones keeps bits", d & 32'h0002_0001, 32'h0002_0001);
      bw(A_STAT, 32'hFFFF_FFFE); settle();
      br(A_STAT, d); chk("R7 write zero clears bit0 only", d & 32'h0002_0001, 32'h0002_0000);
      chk("R7 irq0 low after clear", irq[0], 1'b0);
      bw(A_STAT, 32'hFFFD_FFFF); settle();
      chk("R7 irq17 low after clear", irq[17], 1'b0);
   endtask

   task automatic t_level();
      logic [31:0] d;
      bw(A_SNS1, 32'hB000_0004);
      bw(A_SLT7, 32'hFFFE_0000); settle();
      chk("R6 level high idle", irq[31], 1'b0);
      chk("R6 level low with pin 0", irq[30], 1'b1);
      pin(127, 1'b1); settle();
      chk("R6 level high follows pin", irq[31], 1'b1);
      bw(A_STAT, 32'h0); settle();
      br(A_STAT, d); chk("R6 clear ignored in level modes", d & 32'hC000_0000, 32'hC000_0000);
      pin(127, 1'b0); pin(126, 1'b1); settle();
      chk("R6 level bits drop with pins", irq[31:30], 2'b00);
   endtask

   task automatic t_disabled();
      logic [31:0] d;
      bw(A_SLT1, 32'h0000_0014); settle();
      pin(20, 1'b1); settle(); pin(20, 1'b0); settle(); pin(20, 1'b1); settle();
      br(A_STAT, d); chk("R8 disabled channel no status", d & 32'h10, 32'h0);
      chk("R8 disabled channel no irq", irq[4], 1'b0);
   endtask

   task automatic t_reprogram();
      logic [31:0] d;
      pin(10, 1'b1);
      bw(A_SLT0, 32'h0A8B_0085); settle();
      bw(A_SLT0, 32'h0A8A_0085); settle();
      br(A_STAT, d); chk("R9 source switch no edge", d & 32'h4, 32'h0);
      bw(A_SLT0, 32'h8A8A_0085); settle();
      br(A_STAT, d); chk("R9 enable on high pin no edge", d & 32'h8, 32'h0);
      pin(10, 1'b0); settle(); pin(10, 1'b1); settle();
      chk("R9 reprogrammed channels still detect", irq[3:2], 2'b11);
   endtask

   initial begin
      repeat (3) @(posedge clk);
      @(negedge clk) rst_n = 1'b1;
      #1 t_reset();
      t_rising();
      t_falling();
      t_mask();
      t_clear();
      t_level();
      t_disabled();
      t_reprogram();
      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end

   initial begin
      #400000;
      if (!done) begin
         checks++; fails++;
         $display("FAIL watchdog actual=%h expected=%h", 32'h0, 32'h1);
         $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
         $finish;
      end
   end
endmodule